// File: doc/BRIEF.md
# Multi-Supply Reset Hold-Off Generator

This block turns supply-valid flags from three analog comparators (a 3.3 V rail, a 5 V rail and an adjustable rail) into a system reset. The reset is asserted while any monitored rail is bad. It is released only after all monitored rails have stayed good for a fixed hold-off time. A push-button controller can also demand a hard reset. While that demand is present, the reset is held and the hold-off timer stays at zero.

The 5 V channel can drop out of monitoring. If the board ties the 5 V sense input to the 3.3 V input and the rail is below the upper range point, the 5 V flag is ignored and the block acts as a 3.3 V monitor. Once the rail is above that point, the 5 V channel is monitored again. All flag inputs are asynchronous and are synchronized inside the block. The hold-off length defaults to one fifth of the clock frequency, which is 200 ms.

Top module: `supply_reset_gen`

## Requirements
- R1: When any monitored supply flag (`v33_ok_i`, `vadj_ok_i`, or `v50_ok_i` while the 5 V channel is monitored) is low, `sys_rst_no` is low from the third clock edge after the change onward.
- R2: `sys_rst_no` rises only after every monitored flag and a low `hard_req_i` have been seen in the synchronized domain on HOLD_TICKS consecutive edges. Any fault during the count restarts it from zero.
- R3: `sys_rst_o` is always the logical complement of `sys_rst_no`.
- R4: While `hard_req_i` is high, the reset is held asserted and the count is held at zero. After the request drops, a full HOLD_TICKS count is needed before release.
- R5: When `strap_i` = 1 and `v50_high_i` = 0, the value of `v50_ok_i` has no effect on the outputs.
- R6: When `strap_i` = 1 and `v50_high_i` = 1, or when `strap_i` = 0, a low `v50_ok_i` asserts reset as in R1.
- R7: While `rst_ni` is low, both outputs show reset asserted. After `rst_ni` is released, a full hold-off is needed before the reset output deasserts.
- R8: Every flag input passes through a two-stage synchronizer. With all flags good from the first edge after reset, `sys_rst_no` first reads high after edge 2 + HOLD_TICKS.
- R9: HOLD_TICKS defaults to CLK_HZ/5 clock ticks, which is 200 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low block reset, released synchronously upstream |
| v33_ok_i | input | 1 | 3.3 V rail above threshold (async) |
| v50_ok_i | input | 1 | 5 V rail above threshold (async) |
| vadj_ok_i | input | 1 | Adjustable rail above threshold (async) |
| strap_i | input | 1 | 5 V sense is tied to the 3.3 V sense (async) |
| v50_high_i | input | 1 | 5 V sense above the upper range point (async) |
| hard_req_i | input | 1 | Hard-reset request from the push-button logic (async) |
| sys_rst_no | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The hardest cases to reach are a fault one edge before the count would finish, and a hard request that overlaps a supply fault and outlasts it. The stimulus first measures the exact release cycle. It then places a one-cycle glitch on each channel at the last count value, and makes the request span the fault's removal. The bench model tracks the expected count on every cycle, so any off-by-one in the restart shows up at once.

// File: rtl/sr_pkg.sv
package sr_pkg;
  // Bit positions inside the synchronized flag vector
  localparam int FLG_V33   = 0;
  localparam int FLG_V50   = 1;
  localparam int FLG_VADJ  = 2;
  localparam int FLG_STRAP = 3;
  localparam int FLG_HIGH  = 4;
  localparam int FLG_HARD  = 5;
  localparam int N_FLAGS   = 6;
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] d;
    if (s == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sr_chan_mask.sv
module sr_chan_mask
  import sr_pkg::*;
(
  input  logic [N_FLAGS-1:0] flags_i,
  output logic               all_ok_o,
  output logic               hold_o
);
  logic v50_watch;

  always_comb begin
    v50_watch = !(flags_i[FLG_STRAP] && !flags_i[FLG_HIGH]);
    all_ok_o  = flags_i[FLG_V33] && flags_i[FLG_VADJ] &&
                (flags_i[FLG_V50] || !v50_watch);
    hold_o    = flags_i[FLG_HARD];
  end

  // R5: a strapped, low-range 5 V input never blocks the good verdict
  always_comb begin
    if (flags_i[FLG_STRAP] && !flags_i[FLG_HIGH] &&
        flags_i[FLG_V33] && flags_i[FLG_VADJ])
      p_v50_masked_r5: assert (all_ok_o);
  end
endmodule

// File: rtl/sr_holdoff.sv
module sr_holdoff #(
  parameter int HOLD_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic all_ok_i,
  input  logic hold_i,
  output logic released_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;
  logic          fault;
  logic          cnt_en;

  always_comb begin
    fault  = hold_i || !all_ok_i;
    cnt_en = !fault && !rel_q;
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    if (fault) begin
      cnt_d = '0;
      rel_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) rel_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign released_o = rel_q;

  p_fault_asserts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_ok_i |=> !rel_q);
  p_hard_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0) && !rel_q);
  p_release_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> $past(cnt_q) == LAST && $past(all_ok_i) && !$past(hold_i));
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
  import sr_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int HOLD_TICKS  = CLK_HZ / 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic v33_ok_i,
  input  logic v50_ok_i,
  input  logic vadj_ok_i,
  input  logic strap_i,
  input  logic v50_high_i,
  input  logic hard_req_i,
  output logic sys_rst_no,
  output logic sys_rst_o
);
  logic [N_FLAGS-1:0] raw, synced;
  logic               all_ok, hold, released;

  always_comb begin
    raw            = '0;
    raw[FLG_V33]   = v33_ok_i;
    raw[FLG_V50]   = v50_ok_i;
    raw[FLG_VADJ]  = vadj_ok_i;
    raw[FLG_STRAP] = strap_i;
    raw[FLG_HIGH]  = v50_high_i;
    raw[FLG_HARD]  = hard_req_i;
  end

  sr_sync #(.WIDTH(N_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(raw), .sync_o(synced));

  sr_chan_mask u_mask (.flags_i(synced), .all_ok_o(all_ok), .hold_o(hold));

  sr_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .all_ok_i(all_ok), .hold_i(hold),
    .released_o(released));

  assign sys_rst_no = released;
  assign sys_rst_o  = ~released;

  p_polarity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o != sys_rst_no);
  p_reset_low_r7: assert property (@(posedge clk_i)
    !rst_ni |-> !sys_rst_no);
endmodule

// File: tb/supply_reset_gen_tb.sv
module supply_reset_gen_tb;
  localparam int CLK_HZ = 80;
  localparam int HOLD   = 16;   // expected CLK_HZ/5 (R9)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v33 = 0, v50 = 0, vadj = 0, strap = 0, high = 0, hard = 0;
  logic sys_rst_n, sys_rst;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit model_on = 0;

  always #2.5 clk = ~clk;

  supply_reset_gen #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .v33_ok_i(v33), .v50_ok_i(v50),
    .vadj_ok_i(vadj), .strap_i(strap), .v50_high_i(high), .hard_req_i(hard),
    .sys_rst_no(sys_rst_n), .sys_rst_o(sys_rst));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: input samples delayed through a queue, then a
  // count of consecutive good cycles.
  bit q_ok[$];
  bit q_hard[$];
  int good_run = 0;
  bit exp_rel = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ok = {0, 0}; q_hard = {0, 0};
      good_run = 0; exp_rel = 0;
    end else begin
      bit ok_now, v50_needed;
      if (q_ok[0] && !q_hard[0]) begin
        if (good_run < HOLD) good_run++;
      end else good_run = 0;
      exp_rel = (good_run >= HOLD);
      void'(q_ok.pop_front()); void'(q_hard.pop_front());
      v50_needed = !(strap && !high);
      ok_now = v33 && vadj && (v50 || !v50_needed);
      q_ok.push_back(ok_now); q_hard.push_back(hard);
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(cur_req, sys_rst_n, exp_rel);
      check("R3", sys_rst, ~sys_rst_n);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_all_good();
    v33 = 1; v50 = 1; vadj = 1; strap = 0; high = 0; hard = 0;
  endtask

  // Counts falling edges until release; returns number of rising edges.
  task automatic edges_to_release(output int n);
    n = 0;
    while (sys_rst_n !== 1'b1 && n < 200) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n;
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk); @(negedge clk);
    check("R7", sys_rst_n, 1'b0);
    check("R7", sys_rst, 1'b1);
    rst_n = 1'b1;
    model_on = 1;
    // R8/R9: release at 2 + HOLD edges after inputs go good
    cur_req = "R8";
    set_all_good();
    edges_to_release(n);
    check("R8", n == 2 + HOLD, 1'b1);
    check("R9", n - 2 == CLK_HZ / 5, 1'b1);
    idle(3);
    // R1: each channel drop asserts reset three edges later
    cur_req = "R1";
    v33 = 0; idle(2);
    check("R1", sys_rst_n, 1'b1);
    idle(1);
    check("R1", sys_rst_n, 1'b0);
    v33 = 1; idle(HOLD + 4);
    vadj = 0; idle(4); vadj = 1; idle(HOLD + 4);
    check("R1", sys_rst_n, 1'b1);
    // R2: one-cycle glitch at the last count value restarts the count
    cur_req = "R2";
    v33 = 0; idle(1); v33 = 1;
    idle(2 + HOLD - 1);
    vadj = 0; idle(1); vadj = 1;
    idle(2 + HOLD - 1);
    check("R2", sys_rst_n, 1'b0);
    idle(1);
    check("R2", sys_rst_n, 1'b1);
    // R6: unstrapped, and strapped above the upper point: 5 V watched
    cur_req = "R6";
    v50 = 0; idle(3);
    check("R6", sys_rst_n, 1'b0);
    v50 = 1; idle(HOLD + 4);
    strap = 1; high = 1; idle(4);
    v50 = 0; idle(3);
    check("R6", sys_rst_n, 1'b0);
    // R5: strapped below the upper point: 5 V flag ignored
    cur_req = "R5";
    high = 0; idle(HOLD + 4);
    check("R5", sys_rst_n, 1'b1);
    v50 = 1; idle(4); v50 = 0; idle(4);
    check("R5", sys_rst_n, 1'b1);
    v50 = 1; strap = 0; idle(HOLD + 4);
    // R4: hard request overlapping a fault, outlasting it
    cur_req = "R4";
    hard = 1; idle(3);
    check("R4", sys_rst_n, 1'b0);
    v33 = 0; idle(5); v33 = 1; idle(HOLD + 6);
    check("R4", sys_rst_n, 1'b0);
    hard = 0;
    edges_to_release(n);
    check("R4", n == 2 + HOLD, 1'b1);
    idle(3);
    // R7: block reset mid-operation
    cur_req = "R7";
    model_on = 0;
    @(negedge clk); rst_n = 0; #1;
    check("R7", sys_rst_n, 1'b0);
    check("R7", sys_rst, 1'b1);
    @(negedge clk); rst_n = 1; model_on = 1;
    edges_to_release(n);
    check("R7", n == 2 + HOLD, 1'b1);
    idle(4);
    model_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule